// File: doc/BRIEF.md
# Gated Stochastic Synapse Array

This block holds every input synapse of one spiking neuron and produces the current that the neuron integrates on each clock cycle. Excitatory synapses are switched on by a distance vector: the vector fills one bit at a time as the vehicle moves, and each set bit lets its synapse take part. An enabled excitatory synapse fires at random on about a quarter of the cycles. The random source is a free-running shift-register generator, one per synapse, each started from its own seed. A fired spike reaches the output a fixed number of cycles later and adds one unit of positive current for a single cycle.

Inhibitory synapses take their spikes from other neurons. After the same fixed delay, each spike subtracts one unit of current for two cycles. A second spike on the same synapse while its pulse is still running restarts the two-cycle window. It does not add a second unit. Two fault masks can silence any excitatory or inhibitory synapse, which models a synapse that no longer transmits. The block gives the signed net current and, for monitoring, the excitatory count and the inhibitory magnitude. All three values are registered on the same edge.

Top module: `synapseArray`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with no input active, `excCur`, `inhCur` and `netCur` are all zero. Asserting `rst` during activity clears all three by the next cycle.
- R2: Excitatory synapse i can contribute only while `distVec[i]` is 1 and `excMask[i]` is 0. With the inputs held steady, `excCur` never exceeds the number of such bits, and it is zero when there are none.
- R3: An enabled, unmasked excitatory synapse fires on about one cycle in four. A single synapse gives between 380 and 620 units of `excCur` over 2000 cycles. All 60 synapses together give between 12000 and 18000 units over 1000 cycles.
- R4: Each excitatory spike adds exactly one unit to `excCur` for exactly one cycle, so a single enabled synapse never shows more than 1.
- R5: An inhibitory spike on `inhSpike[j]` sampled at clock edge k makes that synapse add 1 to `inhCur` in the two cycles that follow edges k+DELAY+1 and k+DELAY+2, and 0 at other times. Pulses from different synapses add together.
- R6: Spikes on the same inhibitory synapse at edges k and k+1 extend its contribution to three cycles (after edges k+DELAY+1 through k+DELAY+3), and the value stays at 1 throughout, never 2.
- R7: An inhibitory synapse with `inhMask[j]` set contributes nothing, whatever arrives on `inhSpike[j]`.
- R8: `netCur` is the two's complement value `excCur - inhCur` from the same cycle. It always lies between -NUM_INH and +NUM_EXC, with `excCur` at most NUM_EXC and `inhCur` at most NUM_INH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| distVec | input | NUM_EXC | Enable bit for each excitatory synapse, filled one bit per step |
| excMask | input | NUM_EXC | Fault mask for the excitatory synapses; 1 silences the synapse |
| inhSpike | input | NUM_INH | Spike input from other neurons, one bit per inhibitory synapse |
| inhMask | input | NUM_INH | Fault mask for the inhibitory synapses; 1 silences the synapse |
| excCur | output | clog2(NUM_EXC+1) | Number of excitatory units active in this cycle |
| inhCur | output | clog2(NUM_INH+1) | Number of inhibitory units active in this cycle |
| netCur | output | max width + 1, signed | Net current, excitatory minus inhibitory |

## Verification
Suppose an inhibitory countdown register is stuck or loaded with the wrong value. This shows at `inhCur` within DELAY+3 cycles of a single spike, either as a pulse of the wrong length or as a pulse that does not go away. The deterministic inhibitory sweep over every synapse, with and without masks, catches it. A bad delay stage moves that same pulse by a cycle. A bad gate or a generator stuck at one level shows up in a per-synapse excitatory sweep, either as a masked synapse that still fires, a lone synapse that reaches 2, or a synapse that stays silent for 64 cycles. A generator that is biased only shows after hundreds of cycles, through the rate windows.

// File: rtl/synPkg.sv
package synPkg;

  // Remaining-cycles counter for one inhibitory pulse.
  typedef logic [1:0] inhTimer_t;

  // Number of cycles an inhibitory spike stays active.
  localparam inhTimer_t INH_HOLD = 2'd2;

  // Width able to hold a count from zero to maxVal.
  function automatic int cntWidth(input int maxVal);
    return $clog2(maxVal + 1);
  endfunction

  // Multiplier spreading generator seeds; odd, so all seeds differ.
  localparam int SEED_STEP = 40503;

endpackage

// File: rtl/synLfsrTap.sv
module synLfsrTap #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'h0001,
  parameter int PROB_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  output logic fire
);

  logic [LFSR_W-1:0] state;

  // Galois form, shifting right; never reaches zero from a nonzero seed.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (state[0]) begin
      state <= (state >> 1) ^ TAPS;
    end else begin
      state <= state >> 1;
    end
  end

  // Probability of 1/2**PROB_BITS per cycle.
  assign fire = (state[PROB_BITS-1:0] == '0);

endmodule

// File: rtl/synCtrl.sv
module synCtrl import synPkg::*; #(
  parameter int NUM_EXC = 60,
  parameter int NUM_INH = 40,
  parameter int DELAY = 1,
  parameter int LFSR_W = 16,
  parameter int PROB_BITS = 2,
  parameter int SEED_BASE = 32'h1D2B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] distVec,
  input  logic [NUM_EXC-1:0] excMask,
  input  logic [NUM_INH-1:0] inhSpike,
  input  logic [NUM_INH-1:0] inhMask,
  output logic [NUM_EXC-1:0] excStrobe,
  output logic [NUM_INH-1:0] inhStrobe
);

  logic [NUM_EXC-1:0] rndFire;
  logic [NUM_EXC-1:0] excGated;
  logic [NUM_INH-1:0] inhGated;

  // One random source per excitatory synapse, each from its own seed.
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_tap
    localparam logic [LFSR_W-1:0] RAW_SEED = LFSR_W'(SEED_BASE + (i + 1) * SEED_STEP);
    localparam logic [LFSR_W-1:0] TAP_SEED = (RAW_SEED == '0) ? LFSR_W'(1) : RAW_SEED;
    synLfsrTap #(
      .LFSR_W   (LFSR_W),
      .SEED     (TAP_SEED),
      .PROB_BITS(PROB_BITS)
    ) u_tap (
      .clk (clk),
      .rst (rst),
      .fire(rndFire[i])
    );
  end

  assign excGated = rndFire & distVec & ~excMask;
  assign inhGated = inhSpike & ~inhMask;

  // Delay line of equal length for both synapse types.
  logic [NUM_EXC-1:0] excPipe [DELAY];
  logic [NUM_INH-1:0] inhPipe [DELAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DELAY; s++) begin
        excPipe[s] <= '0;
        inhPipe[s] <= '0;
      end
    end else begin
      excPipe[0] <= excGated;
      inhPipe[0] <= inhGated;
      for (int s = 1; s < DELAY; s++) begin
        excPipe[s] <= excPipe[s-1];
        inhPipe[s] <= inhPipe[s-1];
      end
    end
  end

  assign excStrobe = excPipe[DELAY-1];
  assign inhStrobe = inhPipe[DELAY-1];

endmodule

// File: rtl/synDatapath.sv
module synDatapath import synPkg::*; #(
  parameter int NUM_EXC = 60,
  parameter int NUM_INH = 40,
  parameter int EW = 6,
  parameter int IW = 6,
  parameter int NW = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EXC-1:0]   excStrobe,
  input  logic [NUM_INH-1:0]   inhStrobe,
  output logic [EW-1:0]        excCur,
  output logic [IW-1:0]        inhCur,
  output logic signed [NW-1:0] netCur
);

  logic [NUM_EXC-1:0] excPulse;
  logic [NUM_INH-1:0] inhActive;

  // Excitatory: one cycle of current per spike.
  always_ff @(posedge clk) begin
    if (rst) excPulse <= '0;
    else     excPulse <= excStrobe;
  end

  // Inhibitory: a spike reloads the hold count, so pulses that overlap extend the window.
  for (genvar j = 0; j < NUM_INH; j++) begin : g_inh
    inhTimer_t timer;
    always_ff @(posedge clk) begin
      if (rst)                timer <= '0;
      else if (inhStrobe[j])  timer <= INH_HOLD;
      else if (timer != '0)   timer <= timer - 1'b1;
    end
    assign inhActive[j] = (timer != '0);
  end

  logic [EW-1:0] excSum;
  logic [IW-1:0] inhSum;

  always_comb begin
    excSum = '0;
    for (int i = 0; i < NUM_EXC; i++) excSum = excSum + EW'(excPulse[i]);
  end

  always_comb begin
    inhSum = '0;
    for (int j = 0; j < NUM_INH; j++) inhSum = inhSum + IW'(inhActive[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      excCur <= '0;
      inhCur <= '0;
      netCur <= '0;
    end else begin
      excCur <= excSum;
      inhCur <= inhSum;
      netCur <= $signed(NW'(excSum)) - $signed(NW'(inhSum));
    end
  end

endmodule

// File: rtl/synapseArray.sv
module synapseArray import synPkg::*; #(
  parameter int NUM_EXC = 60,
  parameter int NUM_INH = 40,
  parameter int DELAY = 1,
  parameter int LFSR_W = 16,
  parameter int PROB_BITS = 2,
  parameter int SEED_BASE = 32'h1D2B,
  localparam int EW = cntWidth(NUM_EXC),
  localparam int IW = cntWidth(NUM_INH),
  localparam int NW = ((EW > IW) ? EW : IW) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EXC-1:0]   distVec,
  input  logic [NUM_EXC-1:0]   excMask,
  input  logic [NUM_INH-1:0]   inhSpike,
  input  logic [NUM_INH-1:0]   inhMask,
  output logic [EW-1:0]        excCur,
  output logic [IW-1:0]        inhCur,
  output logic signed [NW-1:0] netCur
);

  logic [NUM_EXC-1:0] excStrobe;
  logic [NUM_INH-1:0] inhStrobe;

  synCtrl #(
    .NUM_EXC  (NUM_EXC),
    .NUM_INH  (NUM_INH),
    .DELAY    (DELAY),
    .LFSR_W   (LFSR_W),
    .PROB_BITS(PROB_BITS),
    .SEED_BASE(SEED_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .distVec  (distVec),
    .excMask  (excMask),
    .inhSpike (inhSpike),
    .inhMask  (inhMask),
    .excStrobe(excStrobe),
    .inhStrobe(inhStrobe)
  );

  synDatapath #(
    .NUM_EXC(NUM_EXC),
    .NUM_INH(NUM_INH),
    .EW     (EW),
    .IW     (IW),
    .NW     (NW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .excStrobe(excStrobe),
    .inhStrobe(inhStrobe),
    .excCur   (excCur),
    .inhCur   (inhCur),
    .netCur   (netCur)
  );

endmodule

// File: rtl/synapseArray_chk.sv
module synapseArray_chk #(
  parameter int NUM_EXC = 60,
  parameter int NUM_INH = 40,
  parameter int DELAY = 1,
  parameter int EW = 6,
  parameter int IW = 6,
  parameter int NW = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_EXC-1:0]   distVec,
  input logic [NUM_EXC-1:0]   excMask,
  input logic [NUM_INH-1:0]   inhSpike,
  input logic [NUM_INH-1:0]   inhMask,
  input logic [EW-1:0]        excCur,
  input logic [IW-1:0]        inhCur,
  input logic signed [NW-1:0] netCur
);

  localparam int EXC_LIM = DELAY + 2;
  localparam int INH_LIM = DELAY + 3;

  // Cycles since an excitatory or inhibitory synapse last had an open input.
  int excQuiet;
  int inhQuiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      excQuiet <= 0;
      inhQuiet <= 0;
    end else begin
      if ((distVec & ~excMask) != '0) excQuiet <= 0;
      else if (excQuiet < EXC_LIM)    excQuiet <= excQuiet + 1;
      if ((inhSpike & ~inhMask) != '0) inhQuiet <= 0;
      else if (inhQuiet < INH_LIM)     inhQuiet <= inhQuiet + 1;
    end
  end

  p_exc_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (excQuiet >= EXC_LIM) |-> (excCur == '0));

  p_inh_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (inhQuiet >= INH_LIM) |-> (inhCur == '0));

  p_inh_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(inhCur != '0) |=> (inhCur != '0));

  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(excCur) <= NUM_EXC) && (int'(inhCur) <= NUM_INH));

  p_net_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(netCur) >= -NUM_INH) && (int'(netCur) <= NUM_EXC));

endmodule

bind synapseArray synapseArray_chk #(
  .NUM_EXC(NUM_EXC),
  .NUM_INH(NUM_INH),
  .DELAY  (DELAY),
  .EW     (EW),
  .IW     (IW),
  .NW     (NW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .distVec (distVec),
  .excMask (excMask),
  .inhSpike(inhSpike),
  .inhMask (inhMask),
  .excCur  (excCur),
  .inhCur  (inhCur),
  .netCur  (netCur)
);

// File: tb/synapseArray_tb.sv
module synapseArray_tb;

  localparam int NE = 60;
  localparam int NI = 40;
  localparam int D  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0] distVec = '0;
  logic [NE-1:0] excMask = '0;
  logic [NI-1:0] inhSpike = '0;
  logic [NI-1:0] inhMask = '0;
  logic [5:0] excCur;
  logic [5:0] inhCur;
  logic signed [6:0] netCur;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  synapseArray u_dut (
    .clk(clk), .rst(rst), .distVec(distVec), .excMask(excMask),
    .inhSpike(inhSpike), .inhMask(inhMask),
    .excCur(excCur), .inhCur(inhCur), .netCur(netCur)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R8: net equals excitatory minus inhibitory in the same cycle
  task automatic checkNet();
    int e = int'(excCur);
    int i = int'(inhCur);
    int n = int'(netCur);
    check(n == e - i, "R8 net", n, e - i);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic flush();
    repeat (D + 4) @(negedge clk);
  endtask

  // R5/R7: one spike vector, then observe the full window
  task automatic inhPulse(input logic [NI-1:0] v, input logic [NI-1:0] m, input string req);
    int exp;
    inhMask = m;
    inhSpike = v;
    @(negedge clk);
    inhSpike = '0;
    for (int j = 1; j <= D + 4; j++) begin
      @(negedge clk);
      exp = (j == D + 1 || j == D + 2) ? $countones(v & ~m) : 0;
      check(int'(inhCur) == exp, req, int'(inhCur), exp);
      checkNet();
    end
  endtask

  // R6: same vector on two consecutive edges
  task automatic inhDouble(input logic [NI-1:0] v);
    int exp;
    inhMask = '0;
    inhSpike = v;
    @(negedge clk);
    for (int j = 1; j <= D + 5; j++) begin
      @(negedge clk);
      if (j == 1) inhSpike = '0;
      exp = (j >= D + 1 && j <= D + 3) ? $countones(v) : 0;
      check(int'(inhCur) == exp, "R6 extend", int'(inhCur), exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int cnt;
    int exp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(excCur == 0 && inhCur == 0 && netCur == 0, "R1 in reset", int'(netCur), 0);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(excCur == 0 && inhCur == 0, "R1 quiet after reset", int'(excCur) + int'(inhCur), 0);
    end

    // R5: every inhibitory synapse alone
    for (int j = 0; j < NI; j++) inhPulse(NI'(1) << j, '0, "R5 single");
    inhPulse('1, '0, "R5 all");
    inhPulse({(NI/2){2'b01}}, '0, "R5 alternate");

    // R7: masks
    inhPulse('1, {(NI/2){2'b10}}, "R7 half masked");
    inhPulse(NI'(1) << 5, NI'(1) << 5, "R7 masked single");
    inhPulse('1, '1, "R7 all masked");

    // R6: repeated spikes on one synapse extend, never add
    inhDouble(NI'(1) << 3);
    inhDouble('1);

    // R5: staggered synapses add: 1, 2, 1
    inhMask = '0;
    inhSpike = NI'(1);
    @(negedge clk);
    inhSpike = NI'(2);
    for (int j = 1; j <= D + 5; j++) begin
      @(negedge clk);
      if (j == 1) inhSpike = '0;
      exp = (j == D + 1) ? 1 : (j == D + 2) ? 2 : (j == D + 3) ? 1 : 0;
      check(int'(inhCur) == exp, "R5 staggered", int'(inhCur), exp);
    end

    // R2/R4: every excitatory synapse alone, then masked
    for (int i = 0; i < NE; i++) begin
      excMask = '0;
      distVec = NE'(1) << i;
      flush();
      cnt = 0;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        check(excCur <= 1, "R4 single synapse", int'(excCur), 1);
        cnt += int'(excCur);
      end
      check(cnt > 0, "R3 synapse fires", cnt, 1);
      excMask = NE'(1) << i;
      flush();
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        check(excCur == 0, "R2 masked", int'(excCur), 0);
      end
    end

    // R2: distance vector filling one step at a time
    excMask = '0;
    distVec = '0;
    flush();
    for (int k = 0; k <= NE; k++) begin
      for (int c = 0; c < 24; c++) begin
        @(negedge clk);
        check(int'(excCur) <= k, "R2 fill bound", int'(excCur), k);
        checkNet();
      end
      distVec = {distVec[NE-2:0], 1'b1};
    end

    // R3: rate of one synapse
    distVec = NE'(1) << 7;
    flush();
    cnt = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      cnt += int'(excCur);
    end
    check(cnt >= 380 && cnt <= 620, "R3 single rate", cnt, 500);

    // R3: rate of all synapses
    distVec = '1;
    flush();
    cnt = 0;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      cnt += int'(excCur);
    end
    check(cnt >= 12000 && cnt <= 18000, "R3 full rate", cnt, 15000);

    // R2: upper half masked
    excMask = {{(NE/2){1'b1}}, {(NE/2){1'b0}}};
    flush();
    cnt = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      check(int'(excCur) <= NE / 2, "R2 half masked bound", int'(excCur), NE / 2);
      cnt += int'(excCur);
    end
    check(cnt >= 2200 && cnt <= 3800, "R2 half masked rate", cnt, 3000);

    // R8: full inhibition against full excitation
    excMask = '0;
    inhMask = '0;
    inhSpike = '1;
    flush();
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      check(int'(inhCur) == NI, "R8 steady inhibition", int'(inhCur), NI);
      checkNet();
      check(int'(netCur) >= -NI && int'(netCur) <= NE - NI, "R8 range", int'(netCur), 0);
    end

    // R1: reset during activity
    rst = 1'b1;
    @(negedge clk);
    check(excCur == 0 && inhCur == 0 && netCur == 0, "R1 mid-run reset",
          int'(excCur) + int'(inhCur), 0);
    inhSpike = '0;
    distVec = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(excCur == 0 && inhCur == 0, "R1 after release", int'(excCur) + int'(inhCur), 0);

    report();
  end

endmodule